// File: doc/BRIEF.md
# SPI Register Access Master

This block is an SPI master that performs single register reads and writes on an attached peripheral. The peripheral is addressed by a 6-bit register file identifier plus an optional sub-address of up to 15 bits. A one-cycle command strobe supplies the identifier, the sub-address, the direction, a byte count and the write data. The block then lowers chip select and sends a header of one, two or three bytes. The header length depends on the sub-address value, and continuation flags sit inside the header bytes themselves. The data bytes follow the header, and the block raises chip select again at the end.

Read data comes back on a 64-bit response port when chip select rises, least significant byte first. One cycle of `done` marks the moment it becomes valid. The serial clock follows SPI mode 0. Each half period lasts a parameterised number of system clocks, and an idle gap of chip-select-high time separates back-to-back transactions.

Top module: `spi_reg_master`

## Requirements
- R1: With sub-address 0 the header is one byte: bit 7 holds the write flag, bit 6 is 0 and bits 5:0 hold the register identifier.
- R2: With a sub-address from 1 to 0x7F the header is two bytes. Byte 0 has bit 6 set. Byte 1 holds the sub-address with bit 7 clear.
- R3: With a sub-address above 0x7F the header is three bytes. Byte 0 has bit 6 set. Byte 1 is sub-address bits 6:0 with bit 7 set. Byte 2 is the sub-address shifted right by 7.
- R4: Bit 7 of header byte 0 is 1 for a write and 0 for a read.
- R5: During a read every data byte sent is 0x00. The byte received in data slot k appears at `rdata[8k+7:8k]`, and bytes above the count read as zero. `rdata` is refreshed in the same way after every transaction.
- R6: `cmd_len` encodes the byte count minus one, so 0 to 7 selects 1 to 8 bytes. A write sends `cmd_wdata` least significant byte first, with exactly that many bytes.
- R7: SPI mode 0 applies. SCLK is low while chip select is high. MOSI changes only while SCLK is low. Every byte goes most significant bit first, and the peripheral's MISO is sampled on rising SCLK edges.
- R8: Chip select stays low from before the first header bit until after the last data bit. Between transactions it stays high for at least one full SCLK period.
- R9: `busy` is high from the cycle after a command is accepted until the block is idle again. A command offered while busy is ignored and never starts a transaction.
- R10: `done` is a single-cycle pulse in the cycle in which chip select returns high, and `rdata` is valid in that cycle.
- R11: Each SCLK high phase and each SCLK low phase lasts `HALF_DIV` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, accepted only while idle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_reg | input | 6 | Register file identifier |
| cmd_sub | input | 15 | Sub-address, 0 means none |
| cmd_len | input | LEN_W (3) | Byte count minus one |
| cmd_wdata | input | 8*MAX_BYTES (64) | Write data, byte 0 sent first |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse as chip select rises |
| rdata | output | 8*MAX_BYTES (64) | Bytes received in the data phase |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |

## Verification
The hardest cases are the boundaries where the header changes length. These are sub-addresses 0, 1, 0x7F, 0x80 and the full 15-bit value, each combined with every byte count in both directions. The sweep crosses all of them, so each header form is followed by each data length. A second hard case is a command arriving while a transaction is in flight. To reach it, the stimulus raises a conflicting command for several cycles in the middle of a transfer. It then counts chip-select falling edges and checks the captured header to confirm that nothing was started or disturbed.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_XFER,
        ST_TRAIL,
        ST_GAP
    } spi_state_e;

    localparam int HDR_MAX_BYTES = 3;
    localparam int REG_ID_W      = 6;
    localparam int SUB_W         = 15;

endpackage

// File: rtl/spi_sclk_tick.sv
module spi_sclk_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == CW'(HALF_DIV - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_hdr_build.sv
module spi_hdr_build
    import spi_reg_pkg::*;
(
    input  logic                 write,
    input  logic [REG_ID_W-1:0]  reg_id,
    input  logic [SUB_W-1:0]     sub,
    output logic [2:0][7:0]      hdr,
    output logic [1:0]           hdr_cnt
);
    always_comb begin
        hdr     = '0;
        hdr[0]  = {write, (sub != '0), reg_id};
        hdr_cnt = 2'd1;
        if (sub == '0) begin
            hdr_cnt = 2'd1;
        end else if (sub <= SUB_W'(8'h7F)) begin
            hdr_cnt = 2'd2;
            hdr[1]  = {1'b0, sub[6:0]};
        end else begin
            hdr_cnt = 2'd3;
            hdr[1]  = {1'b1, sub[6:0]};
            hdr[2]  = sub[14:7];
        end
    end
endmodule

// File: rtl/spi_frame_pack.sv
module spi_frame_pack #(
    parameter int MAX_BYTES = 8
) (
    input  logic [2:0][7:0]                      hdr,
    input  logic [1:0]                           hdr_cnt,
    input  logic                                 write,
    input  logic [$clog2(MAX_BYTES)-1:0]         len,
    input  logic [8*MAX_BYTES-1:0]               wdata,
    output logic [8*(MAX_BYTES+3)-1:0]           frame,
    output logic [$clog2(8*(MAX_BYTES+3)+1)-1:0] frame_bits
);
    localparam int FRAME_BYTES = MAX_BYTES + 3;
    localparam int FRAME_W     = 8 * FRAME_BYTES;
    localparam int CNT_W       = $clog2(FRAME_W + 1);
    localparam int IDX_W       = $clog2(FRAME_BYTES);

    logic [FRAME_BYTES-1:0][7:0] fb;
    logic [IDX_W-1:0]            pidx;

    always_comb begin
        fb   = '0;
        pidx = '0;
        for (int i = 0; i < 3; i++) begin
            if (i < int'(hdr_cnt)) fb[i] = hdr[i];
        end
        for (int k = 0; k < MAX_BYTES; k++) begin
            pidx = IDX_W'(int'(hdr_cnt) + k);
            if (k <= int'(len)) fb[pidx] = write ? wdata[8*k +: 8] : 8'h00;
        end
        for (int i = 0; i < FRAME_BYTES; i++) begin
            frame[FRAME_W-1-8*i -: 8] = fb[i];
        end
        frame_bits = CNT_W'((int'(hdr_cnt) + int'(len) + 1) * 8);
    end
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
    import spi_reg_pkg::*;
#(
    parameter int HALF_DIV  = 2,
    parameter int MAX_BYTES = 8,
    localparam int LEN_W    = $clog2(MAX_BYTES),
    localparam int DATA_W   = 8 * MAX_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [5:0]        cmd_reg,
    input  logic [14:0]       cmd_sub,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int FRAME_W = 8 * (MAX_BYTES + 3);
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        spi_state_e        st;
        logic              cs_n;
        logic              sclk;
        logic              done;
        logic              gap_half;
        logic [CNT_W-1:0]  bit_cnt;
        logic [CNT_W-1:0]  bit_total;
        logic [LEN_W-1:0]  len;
        logic [FRAME_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t q, d;

    logic [2:0][7:0]    hdr;
    logic [1:0]         hdr_cnt;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   frame_bits;
    logic               tick;
    logic [DATA_W-1:0]  rd_asm;

    spi_hdr_build u_hdr (
        .write   (cmd_write),
        .reg_id  (cmd_reg),
        .sub     (cmd_sub),
        .hdr     (hdr),
        .hdr_cnt (hdr_cnt)
    );

    spi_frame_pack #(.MAX_BYTES(MAX_BYTES)) u_pack (
        .hdr        (hdr),
        .hdr_cnt    (hdr_cnt),
        .write      (cmd_write),
        .len        (cmd_len),
        .wdata      (cmd_wdata),
        .frame      (frame),
        .frame_bits (frame_bits)
    );

    spi_sclk_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.st != ST_IDLE),
        .tick  (tick)
    );

    // Reorder the last received bytes: the earliest data byte lands lowest.
    always_comb begin
        rd_asm = '0;
        for (int k = 0; k < MAX_BYTES; k++) begin
            if (k <= int'(q.len)) rd_asm[8*k +: 8] = q.rx[8*(int'(q.len) - k) +: 8];
        end
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.st        = ST_LEAD;
                    d.cs_n      = 1'b0;
                    d.tx        = frame;
                    d.bit_total = frame_bits;
                    d.bit_cnt   = '0;
                    d.len       = cmd_len;
                    d.rx        = '0;
                end
            end
            ST_LEAD: begin
                if (tick) d.st = ST_XFER;
            end
            ST_XFER: begin
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk = 1'b1;
                        d.rx   = {q.rx[DATA_W-2:0], spi_miso};
                    end else begin
                        d.sclk = 1'b0;
                        if (q.bit_cnt == q.bit_total - 1'b1) begin
                            d.st = ST_TRAIL;
                        end else begin
                            d.bit_cnt = q.bit_cnt + 1'b1;
                            d.tx      = {q.tx[FRAME_W-2:0], 1'b0};
                        end
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    d.st       = ST_GAP;
                    d.cs_n     = 1'b1;
                    d.done     = 1'b1;
                    d.gap_half = 1'b0;
                    d.rdata    = rd_asm;
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (q.gap_half) d.st = ST_IDLE;
                    else            d.gap_half = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.cs_n      <= 1'b1;
            q.sclk      <= 1'b0;
            q.done      <= 1'b0;
            q.gap_half  <= 1'b0;
            q.bit_cnt   <= '0;
            q.bit_total <= '0;
            q.len       <= '0;
            q.tx        <= '0;
            q.rx        <= '0;
            q.rdata     <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign rdata    = q.rdata;
    assign spi_cs_n = q.cs_n;
    assign spi_sclk = q.sclk;
    assign spi_mosi = q.tx[FRAME_W-1];
endmodule

// File: rtl/spi_reg_master_chk.sv
module spi_reg_master_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi
);
    assert_cs_high_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);

    assert_sclk_low_when_deselected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    assert_mosi_stable_sclk_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> $stable(spi_mosi));

    assert_done_with_cs_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(spi_cs_n));

    assert_done_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_start_only_from_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> $past(!busy && cmd_valid));
endmodule

bind spi_reg_master spi_reg_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi)
);

// File: tb/tb_spi_reg_master.sv
module tb_spi_reg_master;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int MAXB       = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [5:0]  cmd_reg = '0;
    logic [14:0] cmd_sub = '0;
    logic [2:0]  cmd_len = '0;
    logic [63:0] cmd_wdata = '0;
    logic        busy, done, spi_cs_n, spi_sclk, spi_mosi;
    logic [63:0] rdata;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_reg_master #(.HALF_DIV(HALF), .MAX_BYTES(MAXB)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_reg(cmd_reg), .cmd_sub(cmd_sub), .cmd_len(cmd_len), .cmd_wdata(cmd_wdata),
        .busy(busy), .done(done), .rdata(rdata), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- peripheral model ----------------
    logic [7:0] seed = 8'h00;
    logic [7:0] cap [0:15];
    int  bitpos = 0;
    int  cs_falls = 0;
    time t_rise = 0, t_cs_rise = 0;
    time hi_min = 64'hFFFF_FFFF, hi_max = 0, gap_min = 64'hFFFF_FFFF;
    bit  seen_cs_rise = 0;

    function automatic logic [7:0] resp(input int j);
        return seed + 8'(j * 29 + 5);
    endfunction

    always @(negedge spi_cs_n) begin
        logic [7:0] b;
        if (rst_n) begin
            cs_falls++;
            if (seen_cs_rise && (($time - t_cs_rise) < gap_min)) gap_min = $time - t_cs_rise;
            bitpos = 0;
            for (int i = 0; i < 16; i++) cap[i] = 8'h00;
            b = resp(0);
            spi_miso = b[7];
        end
    end

    always @(posedge spi_cs_n) begin
        t_cs_rise = $time;
        seen_cs_rise = 1;
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            cap[bitpos/8][7 - bitpos%8] = spi_mosi;
            bitpos++;
            t_rise = $time;
        end
    end

    always @(negedge spi_sclk) begin
        logic [7:0] b;
        if (!spi_cs_n) begin
            if (($time - t_rise) < hi_min) hi_min = $time - t_rise;
            if (($time - t_rise) > hi_max) hi_max = $time - t_rise;
            b = resp(bitpos/8);
            spi_miso = b[7 - bitpos%8];
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One transaction, optionally with a conflicting command injected mid-transfer.
    task automatic do_txn(input bit wr, input logic [5:0] rid, input logic [14:0] sub,
                          input logic [2:0] len, input logic [63:0] wd, input bit inject);
        logic [7:0]  exp [0:15];
        logic [63:0] exp_rd;
        int hc, nb, falls0, cyc;
        string rq;
        while (busy) @(negedge clk);
        for (int i = 0; i < 16; i++) exp[i] = 8'h00;
        nb = int'(len) + 1;
        exp[0] = {wr, (sub != 0), rid};
        if (sub == 0) begin
            hc = 1; rq = "R1";
        end else if (sub <= 15'h7F) begin
            hc = 2; exp[1] = 8'(sub); rq = "R2";
        end else begin
            hc = 3; exp[1] = 8'(sub % 128) + 8'h80; exp[2] = 8'(sub / 128); rq = "R3";
        end
        for (int k = 0; k < nb; k++) exp[hc + k] = wr ? 8'(wd >> (8*k)) : 8'h00;
        exp_rd = '0;
        for (int k = 0; k < nb; k++) exp_rd = exp_rd | (64'(resp(hc + k)) << (8*k));
        falls0 = cs_falls;
        cmd_write = wr; cmd_reg = rid; cmd_sub = sub; cmd_len = len; cmd_wdata = wd;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
        if (inject) begin
            repeat (12) @(negedge clk);
            cmd_write = ~wr; cmd_reg = ~rid; cmd_sub = 15'h0; cmd_len = 3'd0;
            cmd_valid = 1'b1;
            repeat (5) @(negedge clk);
            cmd_valid = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R10 done seen", 64'(done), 64'd1);
        chk(spi_cs_n == 1'b1, "R10 cs high with done", 64'(spi_cs_n), 64'd1);
        chk(rdata == exp_rd, "R5 rdata", rdata, exp_rd);
        chk(bitpos == 8*(hc + nb), "R6 bit count", 64'(bitpos), 64'(8*(hc + nb)));
        chk(cap[0] == exp[0], {rq, " R4 header byte0"}, 64'(cap[0]), 64'(exp[0]));
        for (int i = 1; i < hc + nb; i++)
            chk(cap[i] == exp[i], (i < hc) ? {rq, " header byte"} : (wr ? "R6 write byte" : "R5 dummy byte"),
                64'(cap[i]), 64'(exp[i]));
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", 64'(done), 64'd0);
        if (inject) begin
            while (busy) @(negedge clk);
            repeat (10) @(negedge clk);
            chk(cs_falls == falls0 + 1, "R9 command while busy ignored", 64'(cs_falls), 64'(falls0 + 1));
            chk(busy == 1'b0, "R9 idle after ignored command", 64'(busy), 64'd0);
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [14:0] subs [0:6];
        logic [5:0]  regs [0:2];
        int n;
        subs[0] = 15'h0000; subs[1] = 15'h0001; subs[2] = 15'h0055; subs[3] = 15'h007F;
        subs[4] = 15'h0080; subs[5] = 15'h1234; subs[6] = 15'h7FFF;
        regs[0] = 6'h00; regs[1] = 6'h15; regs[2] = 6'h3F;

        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R8 reset cs", 64'(spi_cs_n), 64'd1);
        chk(spi_sclk == 1'b0, "R7 reset sclk", 64'(spi_sclk), 64'd0);
        chk(busy == 1'b0, "R9 reset busy", 64'(busy), 64'd0);
        chk(done == 1'b0, "R10 reset done", 64'(done), 64'd0);
        chk(rdata == 64'd0, "R5 reset rdata", rdata, 64'd0);
        chk(spi_mosi == 1'b0, "R7 reset mosi", 64'(spi_mosi), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        n = 0;
        for (int s = 0; s < 7; s++) begin
            for (int l = 0; l < 8; l++) begin
                for (int w = 0; w < 2; w++) begin
                    seed = 8'(n * 13 + 7);
                    do_txn(w[0], regs[n % 3], subs[s], 3'(l), {$urandom, $urandom}, 1'b0);
                    n++;
                end
            end
        end
        // 40-bit value written as exactly five bytes
        seed = 8'hA5;
        do_txn(1'b1, 6'h0A, 15'h0000, 3'd4, 64'hFFFF_FF12_3456_789A, 1'b0);
        // conflicting commands while busy
        seed = 8'h3C;
        do_txn(1'b0, 6'h21, 15'h0200, 3'd3, 64'd0, 1'b1);
        seed = 8'h77;
        do_txn(1'b1, 6'h05, 15'h0010, 3'd7, 64'h0123_4567_89AB_CDEF, 1'b1);

        chk(hi_min == time'(HALF * CLK_PERIOD), "R11 sclk high min", 64'(hi_min), 64'(HALF * CLK_PERIOD));
        chk(hi_max == time'(HALF * CLK_PERIOD), "R11 sclk high max", 64'(hi_max), 64'(HALF * CLK_PERIOD));
        chk(gap_min >= time'(2 * HALF * CLK_PERIOD), "R8 cs high gap", 64'(gap_min), 64'(2 * HALF * CLK_PERIOD));
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end
endmodule